// File: doc/BRIEF.md
# HDLC Receive Deframer with Station Address Filter

This block takes a serial bit stream, qualified by a receive clock enable, and recovers bit-oriented HDLC frames from it. It hunts for the flag octet, deletes the zeros that a transmitter inserts after runs of five ones, packs the remaining bits into bytes, and runs a frame check over every non-flag bit. Frames whose address field does not name this station are dropped inside the block, so the host sees only its own traffic.

The output is a byte stream with a start marker on the first byte of each accepted frame. The end of the frame is a separate one-cycle marker that carries a four-bit status word. The two frame check bytes are never delivered. A transparent mode skips flag hunting, zero deletion and checking, and delivers every eight enabled input bits as one byte.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: A frame is the content strictly between two flag octets 01111110. Content bits are packed least significant bit first: the first bit received after the opening flag is bit 0 of the first byte.
- R2: Inside a frame, a 0 that follows exactly five consecutive 1s is removed, so a stuffed data byte such as 0xFF or 0x7E is delivered unchanged.
- R3: The frame check runs a reflected CRC (polynomial x^16+x^12+x^5+1, bit-serial constant 0x8408, preset 0xFFFF at each flag) over all content bits, including the 16-bit check field. Status bit 0 is set when the final remainder differs from 0xF0B8. The last two content bytes are never delivered.
- R4: `out_sof` is high together with `out_valid` on the first delivered byte of a frame. `out_eof` is a one-cycle pulse with `out_valid` low that follows the last delivered byte. `out_stat` is valid in that cycle.
- R5: Seven consecutive 1s inside a frame abort it. If bytes were already delivered, `out_eof` is raised with status 4'b0010 (bit 1 alone). Flag hunting then restarts, and the next frame is received normally.
- R6: A frame of fewer than 32 content bits sets status bit 2. A frame delivers bytes only when it holds at least three complete bytes.
- R7: A frame whose content bit count is not a multiple of 8 sets status bit 3.
- R8: With the filter on and `addr_wide` low, the first content byte must equal `station_addr[7:0]` or 0xFF. The upper station byte is ignored. Any other frame gives no output at all.
- R9: With the filter on and `addr_wide` high, the first content byte is the low half of the address and the second is the high half. The 16-bit value must equal `station_addr` or 0xFFFF, or the frame gives no output.
- R10: With `filter_en` low, every frame of three or more bytes is delivered, whatever its address.
- R11: With `transparent` high, every eight enabled input bits are delivered as one byte, with no flag removal, no zero deletion and no `out_sof` or `out_eof`.
- R12: Input bits are consumed only in cycles where `bit_en` is high. `bit_in` in other cycles has no effect.
- R13: While and after reset, before any input bit, `out_valid`, `out_sof` and `out_eof` are low and `out_stat` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Receive bit enable, one bit per high cycle |
| bit_in | input | 1 | Serial receive data |
| transparent | input | 1 | Raw byte mode, no framing |
| addr_wide | input | 1 | 1: 16-bit address field, 0: 8-bit |
| filter_en | input | 1 | Enable station address filtering |
| station_addr | input | 16 | Station address |
| out_valid | output | 1 | Byte strobe |
| out_data | output | 8 | Delivered byte |
| out_sof | output | 1 | First byte of a frame |
| out_eof | output | 1 | End-of-frame pulse, status valid |
| out_stat | output | 4 | {non-octet, short, abort, check error} |

## Verification
Frames are built in the bench with a computed check field and stuffed zeros, then sent with an idle cycle of random data between enabled bits. The address patterns cover a narrow match, a narrow mismatch, a narrow broadcast, and a narrow match with a differing upper station byte. They also cover a wide match, a wide address with its bytes swapped, a wide broadcast, and the filter turned off. Together these show whether the compare uses the right bytes, the right byte order and the broadcast value. Payloads with 0xFF and 0x7E show that stuffed zeros are removed. A corrupted check field, a three-byte frame, a frame with three extra bits, and a mid-frame abort followed by a clean frame each set a different status bit. A raw run of flag and all-ones bytes shows that transparent mode keeps every bit.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

  localparam int BYTE_W = 8;
  localparam int ADDR_W = 16;

  localparam logic [15:0] CRC_PRESET  = 16'hFFFF;
  localparam logic [15:0] CRC_POLY_RV = 16'h8408;
  localparam logic [15:0] CRC_GOOD    = 16'hF0B8;

  localparam logic [BYTE_W-1:0] BCAST_NARROW = '1;
  localparam logic [ADDR_W-1:0] BCAST_WIDE   = '1;

  typedef struct packed {
    logic nonoctet;
    logic runt;
    logic aborted;
    logic chk_err;
  } rx_stat_t;

endpackage

// File: rtl/hdlc_zero_delete.sv
// Flag and abort detection on the raw line, removal of stuffed zeros, and a
// delay line deep enough that the leading bits of a closing flag never leave it.
module hdlc_zero_delete #(
  parameter int FLAG_ONES = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic bit_en,
  input  logic bit_in,
  output logic d_valid,
  output logic d_bit,
  output logic flag_hit,
  output logic abort_hit
);

  localparam int ABORT_ONES = FLAG_ONES + 1;
  localparam int STUFF_ONES = FLAG_ONES - 1;
  localparam int DLY        = FLAG_ONES + 1;
  localparam int CW         = $clog2(ABORT_ONES + 1);
  localparam int DCW        = $clog2(DLY + 1);

  logic [CW-1:0]  ones_q, ones_n;
  logic           infr_q, infr_n;
  logic [DLY-1:0] line_q, line_n;
  logic [DCW-1:0] fill_q, fill_n;
  logic           push, push_bit;

  always_comb begin
    ones_n    = ones_q;
    infr_n    = infr_q;
    fill_n    = fill_q;
    line_n    = line_q;
    push      = 1'b0;
    push_bit  = 1'b0;
    flag_hit  = 1'b0;
    abort_hit = 1'b0;
    d_valid   = 1'b0;
    d_bit     = 1'b0;
    if (clr) begin
      ones_n = '0;
      infr_n = 1'b0;
      fill_n = '0;
    end else if (bit_en) begin
      if (bit_in) begin
        ones_n = (ones_q == CW'(ABORT_ONES)) ? ones_q : ones_q + 1'b1;
        if (infr_q) begin
          if (ones_q == CW'(ABORT_ONES - 1)) begin
            abort_hit = 1'b1;
            infr_n    = 1'b0;
            fill_n    = '0;
          end else begin
            push     = 1'b1;
            push_bit = 1'b1;
          end
        end
      end else begin
        ones_n = '0;
        if (ones_q == CW'(FLAG_ONES)) begin
          flag_hit = 1'b1;
          infr_n   = 1'b1;
          fill_n   = '0;
        end else if (infr_q && (ones_q != CW'(STUFF_ONES))) begin
          push = 1'b1;
        end
      end
    end
    if (push) begin
      line_n = {push_bit, line_q[DLY-1:1]};
      if (fill_q == DCW'(DLY)) begin
        d_valid = 1'b1;
        d_bit   = line_q[0];
      end else begin
        fill_n = fill_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ones_q <= '0;
      infr_q <= 1'b0;
      line_q <= '0;
      fill_q <= '0;
    end else begin
      ones_q <= ones_n;
      infr_q <= infr_n;
      line_q <= line_n;
      fill_q <= fill_n;
    end
  end

endmodule

// File: rtl/hdlc_crc_acc.sv
// Bit-serial reflected CRC accumulator.
module hdlc_crc_acc #(
  parameter int           W      = 16,
  parameter logic [W-1:0] POLY   = 16'h8408,
  parameter logic [W-1:0] PRESET = 16'hFFFF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         init,
  input  logic         en,
  input  logic         bit_in,
  output logic [W-1:0] crc
);

  logic [W-1:0] crc_q, crc_n;

  always_comb begin
    crc_n = crc_q;
    if (init) begin
      crc_n = PRESET;
    end else if (en) begin
      crc_n = {1'b0, crc_q[W-1:1]} ^ ((crc_q[0] ^ bit_in) ? POLY : '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= PRESET;
    else        crc_q <= crc_n;
  end

  assign crc = crc_q;

endmodule

// File: rtl/hdlc_byte_pack.sv
// LSB-first byte assembly with a bit phase and a saturating byte count.
module hdlc_byte_pack #(
  parameter int BW      = 8,
  parameter int CNT_MAX = 4,
  localparam int PW     = $clog2(BW),
  localparam int NW     = $clog2(CNT_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic          bit_in,
  output logic          byte_rdy,
  output logic [BW-1:0] byte_out,
  output logic [PW-1:0] phase,
  output logic [NW-1:0] nbytes
);

  logic [BW-1:0] sh_q, sh_n;
  logic [PW-1:0] ph_q, ph_n;
  logic [NW-1:0] nb_q, nb_n;

  always_comb begin
    sh_n     = sh_q;
    ph_n     = ph_q;
    nb_n     = nb_q;
    byte_rdy = 1'b0;
    if (clr) begin
      ph_n = '0;
      nb_n = '0;
    end else if (en) begin
      sh_n = {bit_in, sh_q[BW-1:1]};
      if (ph_q == PW'(BW - 1)) begin
        ph_n     = '0;
        byte_rdy = 1'b1;
        if (nb_q != NW'(CNT_MAX)) nb_n = nb_q + 1'b1;
      end else begin
        ph_n = ph_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
      ph_q <= '0;
      nb_q <= '0;
    end else begin
      sh_q <= sh_n;
      ph_q <= ph_n;
      nb_q <= nb_n;
    end
  end

  assign byte_out = sh_n;
  assign phase    = ph_q;
  assign nbytes   = nb_q;

endmodule

// File: rtl/hdlc_frame_ctl.sv
// Two-byte hold-back, address decision, delivery and end-of-frame status.
module hdlc_frame_ctl
  import hdlc_rx_pkg::*;
#(
  parameter int MIN_BYTES = 4,
  localparam int NW       = $clog2(MIN_BYTES + 1),
  localparam int PW       = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              transparent,
  input  logic              addr_wide,
  input  logic              filter_en,
  input  logic [ADDR_W-1:0] station_addr,
  input  logic              flag_hit,
  input  logic              abort_hit,
  input  logic              byte_rdy,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic [PW-1:0]     phase,
  input  logic [NW-1:0]     nbytes,
  input  logic [15:0]       crc,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_sof,
  output logic              out_eof,
  output rx_stat_t          out_stat
);

  logic [BYTE_W-1:0] h0_q, h0_n, h1_q, h1_n;
  logic              acc_q, acc_n;
  logic              v_q, v_n, sof_q, sof_n, eof_q, eof_n;
  logic [BYTE_W-1:0] d_q, d_n;
  rx_stat_t          st_q, st_n;
  logic              addr_ok, take;

  always_comb begin
    if (!filter_en) begin
      addr_ok = 1'b1;
    end else if (addr_wide) begin
      addr_ok = ({h1_q, h0_q} == station_addr) || ({h1_q, h0_q} == BCAST_WIDE);
    end else begin
      addr_ok = (h0_q == station_addr[BYTE_W-1:0]) || (h0_q == BCAST_NARROW);
    end
  end

  always_comb begin
    h0_n  = h0_q;
    h1_n  = h1_q;
    acc_n = acc_q;
    v_n   = 1'b0;
    sof_n = 1'b0;
    eof_n = 1'b0;
    d_n   = d_q;
    st_n  = st_q;
    take  = 1'b0;
    if (transparent) begin
      acc_n = 1'b0;
      if (byte_rdy) begin
        v_n = 1'b1;
        d_n = byte_in;
      end
    end else if (flag_hit || abort_hit) begin
      if (acc_q) begin
        eof_n = 1'b1;
        if (abort_hit) begin
          st_n = '{nonoctet: 1'b0, runt: 1'b0, aborted: 1'b1, chk_err: 1'b0};
        end else begin
          st_n = '{nonoctet: (phase != '0),
                   runt:     (nbytes < NW'(MIN_BYTES)),
                   aborted:  1'b0,
                   chk_err:  (crc != CRC_GOOD)};
        end
      end
      acc_n = 1'b0;
    end else if (byte_rdy) begin
      if (nbytes == NW'(0)) begin
        h0_n = byte_in;
      end else if (nbytes == NW'(1)) begin
        h1_n = byte_in;
      end else begin
        take = acc_q || ((nbytes == NW'(2)) && addr_ok);
        if (take) begin
          v_n   = 1'b1;
          d_n   = h0_q;
          sof_n = !acc_q;
          acc_n = 1'b1;
        end
        h0_n = h1_q;
        h1_n = byte_in;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h0_q  <= '0;
      h1_q  <= '0;
      acc_q <= 1'b0;
      v_q   <= 1'b0;
      sof_q <= 1'b0;
      eof_q <= 1'b0;
      d_q   <= '0;
      st_q  <= '0;
    end else begin
      h0_q  <= h0_n;
      h1_q  <= h1_n;
      acc_q <= acc_n;
      v_q   <= v_n;
      sof_q <= sof_n;
      eof_q <= eof_n;
      d_q   <= d_n;
      st_q  <= st_n;
    end
  end

  assign out_valid = v_q;
  assign out_data  = d_q;
  assign out_sof   = sof_q;
  assign out_eof   = eof_q;
  assign out_stat  = st_q;

endmodule

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
  import hdlc_rx_pkg::*;
#(
  parameter int MIN_FRAME_BYTES = 4,
  parameter int FLAG_ONES       = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bit_en,
  input  logic        bit_in,
  input  logic        transparent,
  input  logic        addr_wide,
  input  logic        filter_en,
  input  logic [15:0] station_addr,
  output logic        out_valid,
  output logic [7:0]  out_data,
  output logic        out_sof,
  output logic        out_eof,
  output logic [3:0]  out_stat
);

  localparam int NW = $clog2(MIN_FRAME_BYTES + 1);
  localparam int PW = $clog2(BYTE_W);

  logic              mode_q, mode_chg;
  logic              d_valid, d_bit, flag_hit, abort_hit;
  logic              pk_en, pk_bit, pk_clr, byte_rdy;
  logic [BYTE_W-1:0] byte_val;
  logic [PW-1:0]     phase;
  logic [NW-1:0]     nbytes;
  logic [15:0]       crc;
  rx_stat_t          stat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= 1'b0;
    else        mode_q <= transparent;
  end

  assign mode_chg = transparent ^ mode_q;
  assign pk_en    = transparent ? bit_en : d_valid;
  assign pk_bit   = transparent ? bit_in : d_bit;
  assign pk_clr   = mode_chg | flag_hit | abort_hit;

  hdlc_zero_delete #(.FLAG_ONES(FLAG_ONES)) i_zdel (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (transparent | mode_chg),
    .bit_en   (bit_en),
    .bit_in   (bit_in),
    .d_valid  (d_valid),
    .d_bit    (d_bit),
    .flag_hit (flag_hit),
    .abort_hit(abort_hit)
  );

  hdlc_crc_acc #(.W(16), .POLY(CRC_POLY_RV), .PRESET(CRC_PRESET)) i_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .init  (flag_hit),
    .en    (d_valid),
    .bit_in(d_bit),
    .crc   (crc)
  );

  hdlc_byte_pack #(.BW(BYTE_W), .CNT_MAX(MIN_FRAME_BYTES)) i_pack (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (pk_clr),
    .en      (pk_en),
    .bit_in  (pk_bit),
    .byte_rdy(byte_rdy),
    .byte_out(byte_val),
    .phase   (phase),
    .nbytes  (nbytes)
  );

  hdlc_frame_ctl #(.MIN_BYTES(MIN_FRAME_BYTES)) i_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .transparent (transparent),
    .addr_wide   (addr_wide),
    .filter_en   (filter_en),
    .station_addr(station_addr),
    .flag_hit    (flag_hit),
    .abort_hit   (abort_hit),
    .byte_rdy    (byte_rdy),
    .byte_in     (byte_val),
    .phase       (phase),
    .nbytes      (nbytes),
    .crc         (crc),
    .out_valid   (out_valid),
    .out_data    (out_data),
    .out_sof     (out_sof),
    .out_eof     (out_eof),
    .out_stat    (stat)
  );

  assign out_stat = stat;

endmodule

// File: rtl/hdlc_rx_deframer_chk.sv
module hdlc_rx_deframer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bit_en,
  input logic       transparent,
  input logic       out_valid,
  input logic       out_sof,
  input logic       out_eof,
  input logic [3:0] out_stat
);

  logic open_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                open_q <= 1'b0;
    else if (out_eof)          open_q <= 1'b0;
    else if (out_sof)          open_q <= 1'b1;
    else if (transparent)      open_q <= 1'b0;
  end

  AST_SOF_WITH_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> out_valid);                                            // R4
  AST_EOF_WITHOUT_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    out_eof |-> !out_valid);                                           // R4
  AST_SOF_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> !open_q);                                              // R4
  AST_EOF_CLOSES_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    out_eof |-> open_q);                                               // R8
  AST_ABORT_STATUS_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_eof && out_stat[1]) |-> (out_stat == 4'b0010));               // R5
  AST_RAW_NO_MARKERS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(transparent) |-> (!out_sof && !out_eof));                    // R11
  AST_QUIET_WITHOUT_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bit_en) |-> (!out_valid && !out_eof));                      // R12

endmodule

bind hdlc_rx_deframer hdlc_rx_deframer_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bit_en     (bit_en),
  .transparent(transparent),
  .out_valid  (out_valid),
  .out_sof    (out_sof),
  .out_eof    (out_eof),
  .out_stat   (out_stat)
);

// File: tb/test_hdlc_rx_deframer.sv
module test_hdlc_rx_deframer;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        wide;
    logic        fen;
    logic [15:0] sta;
    logic [2:0]  nb;
    logic [47:0] data;
    logic        fcs_ok;
    logic [1:0]  extra;
  } vec_t;

  localparam int NVEC = 11;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b1, 16'h0003, 3'd4, 48'h0000_2211_3F03, 1'b1, 2'd0},
    '{1'b0, 1'b1, 16'h0003, 3'd4, 48'h0000_2211_3F05, 1'b1, 2'd0},
    '{1'b0, 1'b1, 16'h0003, 3'd3, 48'h0000_0066_55FF, 1'b1, 2'd0},
    '{1'b1, 1'b1, 16'hA5C3, 3'd6, 48'h10FF_FF7E_A5C3, 1'b1, 2'd0},
    '{1'b1, 1'b1, 16'hA5C3, 3'd4, 48'h0000_1234_C3A5, 1'b1, 2'd0},
    '{1'b0, 1'b0, 16'h0003, 3'd4, 48'h0000_8899_0042, 1'b1, 2'd0},
    '{1'b0, 1'b1, 16'h0003, 3'd4, 48'h0000_4433_2203, 1'b0, 2'd0},
    '{1'b0, 1'b1, 16'h0003, 3'd1, 48'h0000_0000_0003, 1'b1, 2'd0},
    '{1'b0, 1'b1, 16'h0003, 3'd3, 48'h0000_00F0_1E03, 1'b1, 2'd3},
    '{1'b1, 1'b1, 16'hA5C3, 3'd4, 48'h0000_BEEF_FFFF, 1'b1, 2'd0},
    '{1'b0, 1'b1, 16'h7703, 3'd4, 48'h0000_6655_0003, 1'b1, 2'd0}
  };

  logic        clk, rst_n, bit_en, bit_in, transparent, addr_wide, filter_en;
  logic [15:0] station_addr;
  logic        out_valid, out_sof, out_eof;
  logic [7:0]  out_data;
  logic [3:0]  out_stat;

  int total, bad;
  logic [15:0] lfsr;

  logic [7:0] rxq[$];
  logic       sofq[$];
  int         eof_cnt;
  logic [3:0] last_stat;

  logic fb [0:127];
  int   fn;

  hdlc_rx_deframer i_hdlc_rx_deframer (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
    .transparent(transparent), .addr_wide(addr_wide), .filter_en(filter_en),
    .station_addr(station_addr), .out_valid(out_valid), .out_data(out_data),
    .out_sof(out_sof), .out_eof(out_eof), .out_stat(out_stat)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        rxq.push_back(out_data);
        sofq.push_back(out_sof);
      end
      if (out_eof) begin
        eof_cnt   = eof_cnt + 1;
        last_stat = out_stat;
      end
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // R12: each bit is enabled for one edge, followed by one edge with
  // bit_en low and random data on bit_in.
  task automatic send_bit(input logic b);
    @(posedge clk); #1;
    bit_en = 1'b1;
    bit_in = b;
    @(posedge clk); #1;
    bit_en = 1'b0;
    lfsr   = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    bit_in = lfsr[0];
  endtask

  task automatic send_raw_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) send_bit(v[i]);
  endtask

  task automatic send_idle(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b1);
  endtask

  task automatic add_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) begin
      fb[fn] = v[i];
      fn++;
    end
  endtask

  function automatic logic [15:0] crc_over(input int n);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < n; i++)
      c = (c >> 1) ^ (((c[0] ^ fb[i]) == 1'b1) ? 16'h8408 : 16'h0000);
    return c;
  endfunction

  function automatic logic [7:0] byte_at(input int k);
    logic [7:0] v;
    for (int i = 0; i < 8; i++) v[i] = fb[8 * k + i];
    return v;
  endfunction

  task automatic send_stuffed(input int n);
    int ones = 0;
    for (int i = 0; i < n; i++) begin
      send_bit(fb[i]);
      if (fb[i]) begin
        ones++;
        if (ones == 5) begin
          send_bit(1'b0);
          ones = 0;
        end
      end else begin
        ones = 0;
      end
    end
  endtask

  task automatic clear_rx();
    rxq.delete();
    sofq.delete();
    eof_cnt   = 0;
    last_stat = 4'h0;
  endtask

  function automatic string vtag(input int i);
    case (i)
      0:       return "R1/R12";
      1:       return "R8";
      2:       return "R8";
      3:       return "R2";
      4:       return "R9";
      5:       return "R10";
      6:       return "R3";
      7:       return "R6";
      8:       return "R7";
      9:       return "R9";
      default: return "R8";
    endcase
  endfunction

  task automatic run_vec(input int vi);
    vec_t        v = VECS[vi];
    logic [15:0] fcs, res;
    logic [7:0]  b0, b1;
    logic        match;
    int          full, ndel, nchk;
    logic [3:0]  exp_stat;
    string       tg = vtag(vi);

    addr_wide    = v.wide;
    filter_en    = v.fen;
    station_addr = v.sta;
    fn = 0;
    for (int k = 0; k < int'(v.nb); k++) add_byte(v.data[8 * k +: 8]);
    fcs = ~crc_over(fn);
    if (!v.fcs_ok) fcs = fcs ^ 16'h1234;
    add_byte(fcs[7:0]);
    add_byte(fcs[15:8]);
    for (int k = 0; k < int'(v.extra); k++) begin
      fb[fn] = k[0];
      fn++;
    end

    res  = crc_over(fn);
    full = fn / 8;
    b0   = byte_at(0);
    b1   = byte_at(1);
    if (!v.fen)      match = 1'b1;
    else if (v.wide) match = ({b1, b0} == v.sta) || ({b1, b0} == 16'hFFFF);
    else             match = (b0 == v.sta[7:0]) || (b0 == 8'hFF);
    ndel = (match && full >= 3) ? full - 2 : 0;
    exp_stat = {(fn % 8) != 0, fn < 32, 1'b0, res != 16'hF0B8};

    clear_rx();
    send_idle(10);
    send_raw_byte(8'h7E);
    send_stuffed(fn);
    send_raw_byte(8'h7E);
    send_idle(10);

    chk(tg, "byte count", rxq.size(), ndel);
    nchk = (rxq.size() < ndel) ? rxq.size() : ndel;
    for (int k = 0; k < nchk; k++) begin
      chk(tg, "byte", rxq[k], byte_at(k));
      chk("R4", "sof marker", sofq[k], k == 0);
    end
    chk("R4", "eof count", eof_cnt, (ndel > 0) ? 1 : 0);
    if (ndel > 0) chk(tg, "status", last_stat, exp_stat);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    total = 0; bad = 0; lfsr = 16'hACE1;
    rst_n = 1'b0; bit_en = 1'b0; bit_in = 1'b0; transparent = 1'b0;
    addr_wide = 1'b0; filter_en = 1'b1; station_addr = 16'h0003;
    clear_rx();

    // R13: outputs quiet in reset and just after release
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R13", "valid in reset", out_valid, 0);
    chk("R13", "sof/eof in reset", {out_sof, out_eof}, 0);
    chk("R13", "stat in reset", out_stat, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R13", "outputs after release", {out_valid, out_sof, out_eof, out_stat}, 0);

    for (int vi = 0; vi < NVEC; vi++) run_vec(vi);

    // R5: abort after four bytes, then a clean frame is still received
    filter_en = 1'b0;
    clear_rx();
    send_idle(10);
    send_raw_byte(8'h7E);
    send_raw_byte(8'h03);
    send_raw_byte(8'hAA);
    send_raw_byte(8'h55);
    send_raw_byte(8'h10);
    send_idle(12);
    chk("R5", "abort bytes", rxq.size(), 1);
    if (rxq.size() > 0) chk("R5", "abort first byte", rxq[0], 8'h03);
    chk("R5", "abort eof count", eof_cnt, 1);
    chk("R5", "abort status", last_stat, 4'b0010);
    run_vec(0);

    // R11: raw bytes including flag and all-ones patterns
    transparent = 1'b1;
    repeat (3) @(posedge clk);
    clear_rx();
    send_raw_byte(8'h7E);
    send_raw_byte(8'hFF);
    send_raw_byte(8'h3C);
    repeat (4) @(posedge clk);
    chk("R11", "raw byte count", rxq.size(), 3);
    if (rxq.size() == 3) begin
      chk("R11", "raw byte 0", rxq[0], 8'h7E);
      chk("R11", "raw byte 1", rxq[1], 8'hFF);
      chk("R11", "raw byte 2", rxq[2], 8'h3C);
      chk("R11", "raw sof", {sofq[0], sofq[1], sofq[2]}, 0);
    end
    chk("R11", "raw eof", eof_cnt, 0);
    transparent = 1'b0;
    repeat (3) @(posedge clk);
    run_vec(5);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule